// File: doc/BRIEF.md
# Clock and Reset Configuration Register File

This block is the software-visible register file of a chip's power, reset and clock controller. Firmware reaches it through a simple 32-bit bus with an address, an access size, separate read and write strobes, write data, registered read data and an error pulse. It keeps nine 32-bit configuration words: the crystal oscillator setup, the first configuration word of each of three PLLs (core, memory, network), the second configuration word of the memory and network PLLs, the core clock source select, a per-device reset vector and a clock-mux status word.

No real clocking hardware sits behind the registers, so the block makes the hardware look healthy to firmware. The oscillator always reads ready, and every PLL always reads locked with internal feedback selected, whatever software writes. Any access that does not hit a mapped register with a full-word size is refused. A refused read returns zero, a refused write leaves every register alone, and both raise a one-cycle error pulse.

Top module: `clkrst_cfg_regs`

## Requirements
- R1: After reset, with offsets shown in hex, the registers read: 0x00 oscillator = 0xC000_0000 (enable bit 30, ready bit 31), and 0x04 core PLL, 0x08 memory PLL and 0x10 network PLL first words = 0x8201_87C1 (divr[5:0]=1, divf[14:6]=31, divq[17:15]=3, feedback bit 25, lock bit 31). The 0x24 clock select reads 0x0000_0001 (bit 0 = 1 selects the reference clock). 0x0C and 0x1C (second PLL words), 0x28 device reset and 0x2C mux status read 0.
- R2: A legal write to the oscillator register at 0x00 stores the data with bit 31 (ready) forced to 1.
- R3: A legal write to any PLL first word (0x04, 0x08, 0x10) stores the data with bit 25 (feedback select) and bit 31 (lock) forced to 1.
- R4: A legal write to 0x0C, 0x1C, 0x24, 0x28 or 0x2C stores the data unchanged.
- R5: bus_rdata is registered. It shows the addressed register one cycle after bus_rd is sampled high and holds its value in every cycle without a read.
- R6: A read that is refused returns bus_rdata = 0 in the following cycle.
- R7: A write that is refused changes no register.
- R8: An access is legal only with bus_size = 2 (word). The encodings 0 (byte), 1 (half) and 3 (reserved) are refused, even at a mapped offset.
- R9: bus_err is high for exactly one cycle, in the cycle after a refused read or write is sampled. It stays low after legal accesses and idle cycles.
- R10: An address that is not word aligned, that lies in the unused gaps (0x14, 0x18, 0x20), or that lies at or above 0x30 is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Byte offset of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe, sampled at the rising edge |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_err | output | 1 | One-cycle pulse for a refused access |

## Verification
The embedded assertions check several rules on every cycle: the forced status bits never read as zero, a register changes only when its select is active, at most one register is selected, read data holds between reads, a refused read yields zero together with the error pulse, and the error stays quiet after idle cycles. Only the bench scenarios can show the rest. These are the exact power-on values, that each offset reaches the right register with the right mask, that gap, misaligned, out-of-window and short accesses are all refused, and that a refused write really leaves all nine registers unchanged. The bench shows this by reading every register back against an independent model after random and directed traffic.

// File: rtl/clkrst_cfg_pkg.sv
// Package: shared constants, access-size encoding and per-slot
// configuration (offset, power-on value, forced-one mask) for the
// clock/reset configuration register file.
// Assumes: nine 32-bit slots, byte offsets inside a 6-bit window.
package clkrst_cfg_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int NSLOT  = 9;

    // Access size encoding on the bus
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Slot indices
    typedef enum int {
        SLOT_OSC      = 0,
        SLOT_CPLL_A   = 1,
        SLOT_MPLL_A   = 2,
        SLOT_MPLL_B   = 3,
        SLOT_NPLL_A   = 4,
        SLOT_NPLL_B   = 5,
        SLOT_CLK_SRC  = 6,
        SLOT_DEV_RST  = 7,
        SLOT_MUX_STAT = 8
    } slot_e;

    // Oscillator field positions
    localparam int OSC_EN_BIT  = 30;
    localparam int OSC_RDY_BIT = 31;

    // PLL first-word field positions
    localparam int PLL_R_LSB    = 0;
    localparam int PLL_F_LSB    = 6;
    localparam int PLL_Q_LSB    = 15;
    localparam int PLL_FB_BIT   = 25;
    localparam int PLL_LOCK_BIT = 31;

    // PLL power-on divider settings
    localparam int PLL_R_INIT = 1;
    localparam int PLL_F_INIT = 31;
    localparam int PLL_Q_INIT = 3;

    // Clock source select: bit 0 high picks the reference clock
    localparam int CLK_SRC_REF = 1;

    // Byte offset of a slot
    function automatic int slot_offset(input int idx);
        case (idx)
            0:       return 'h00;
            1:       return 'h04;
            2:       return 'h08;
            3:       return 'h0C;
            4:       return 'h10;
            5:       return 'h1C;
            6:       return 'h24;
            7:       return 'h28;
            default: return 'h2C;
        endcase
    endfunction

    // True for the three PLL first words
    function automatic bit slot_is_pll_a(input int idx);
        return (idx == SLOT_CPLL_A) || (idx == SLOT_MPLL_A) || (idx == SLOT_NPLL_A);
    endfunction

    // Bits that always read as one in a slot
    function automatic logic [DATA_W-1:0] slot_force(input int idx);
        logic [DATA_W-1:0] m;
        m = '0;
        if (idx == SLOT_OSC) begin
            m[OSC_RDY_BIT] = 1'b1;
        end else if (slot_is_pll_a(idx)) begin
            m[PLL_FB_BIT]   = 1'b1;
            m[PLL_LOCK_BIT] = 1'b1;
        end
        return m;
    endfunction

    // Power-on value of a slot
    function automatic logic [DATA_W-1:0] slot_reset(input int idx);
        logic [DATA_W-1:0] v;
        v = '0;
        if (idx == SLOT_OSC) begin
            v[OSC_EN_BIT]  = 1'b1;
            v[OSC_RDY_BIT] = 1'b1;
        end else if (slot_is_pll_a(idx)) begin
            v = v | (DATA_W'(PLL_R_INIT) << PLL_R_LSB)
                  | (DATA_W'(PLL_F_INIT) << PLL_F_LSB)
                  | (DATA_W'(PLL_Q_INIT) << PLL_Q_LSB);
            v[PLL_FB_BIT]   = 1'b1;
            v[PLL_LOCK_BIT] = 1'b1;
        end else if (idx == SLOT_CLK_SRC) begin
            v = DATA_W'(CLK_SRC_REF);
        end
        return v;
    endfunction

endpackage

// File: rtl/clkrst_addr_decode.sv
// Module: address and size decoder. Raises one select per slot when a
// full-word access hits that slot's offset; reports whether the access
// hit anything.
// Assumes: offsets are word aligned, so a misaligned address never matches.
module clkrst_addr_decode
    import clkrst_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NS = NSLOT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic [NS-1:0] sel,
    output logic          hit
);

    logic size_ok;

    // Only word-sized accesses are legal
    assign size_ok = (size == SZ_WORD);

    // One comparator per slot
    for (genvar i = 0; i < NS; i++) begin : g_cmp
        assign sel[i] = size_ok && (addr == AW'(slot_offset(i)));
    end

    // Any slot matched
    assign hit = |sel;

    // R10
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: rtl/clkrst_cfg_slot.sv
// Module: one configuration register. It loads write data on its write
// enable, ORs in a fixed mask of forced-one bits and starts at a
// parameterised power-on value.
// Assumes: the power-on value already contains the forced bits.
module clkrst_cfg_slot #(
    parameter int            W          = 32,
    parameter logic [W-1:0]  INIT_VAL   = '0,
    parameter logic [W-1:0]  FORCE_ONES = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Storage: reset to power-on value, load masked data on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT_VAL;
        end else if (we) begin
            q <= wdata | FORCE_ONES;
        end
    end

    // R2 R3
    forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q & FORCE_ONES) == FORCE_ONES);

    // R7
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/clkrst_read_path.sv
// Module: registered read data and error pulse. A legal read captures
// the selected slot, a refused read captures zero, and a refused read
// or write pulses the error output for one cycle.
// Assumes: at most one select is high; read data holds without a read.
module clkrst_read_path #(
    parameter int DW = 32,
    parameter int NS = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd,
    input  logic                  wr,
    input  logic                  hit,
    input  logic [NS-1:0]         sel,
    input  logic [NS-1:0][DW-1:0] slots,
    output logic [DW-1:0]         rdata,
    output logic                  err
);

    logic [DW-1:0] mux_out;

    // AND-OR read mux over the one-hot selects
    always_comb begin
        mux_out = '0;
        for (int i = 0; i < NS; i++) begin
            mux_out = mux_out | (slots[i] & {DW{sel[i]}});
        end
    end

    // Read data register: updated only by a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= hit ? mux_out : '0;
        end
    end

    // Error pulse register: one cycle per refused access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else begin
            err <= (rd || wr) && !hit;
        end
    end

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    // R6
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit) |=> (rdata == '0) && err);

    // R9
    idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd || wr) |=> !err);

endmodule

// File: rtl/clkrst_cfg_regs.sv
// Module: top of the clock/reset configuration register file. It ties
// the decoder, nine configuration slots and the read path together.
// Assumes: a single-cycle bus; a write takes effect at the sampling
// edge, and a read in the same cycle returns the value before that write.
module clkrst_cfg_regs
    import clkrst_cfg_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int DATA_W_P = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W_P-1:0] bus_addr,
    input  logic [1:0]          bus_size,
    input  logic                bus_wr,
    input  logic [DATA_W_P-1:0] bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W_P-1:0] bus_rdata,
    output logic                bus_err
);

    localparam int NS = NSLOT;

    logic [NS-1:0]               sel;
    logic                        hit;
    logic [NS-1:0][DATA_W_P-1:0] slot_q;

    // Address/size decode
    clkrst_addr_decode #(
        .AW (ADDR_W_P),
        .NS (NS)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .size  (bus_size),
        .sel   (sel),
        .hit   (hit)
    );

    // Configuration slots, each with its own power-on value and mask
    for (genvar i = 0; i < NS; i++) begin : g_slot
        clkrst_cfg_slot #(
            .W          (DATA_W_P),
            .INIT_VAL   (DATA_W_P'(slot_reset(i))),
            .FORCE_ONES (DATA_W_P'(slot_force(i)))
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_wr && sel[i]),
            .wdata (bus_wdata),
            .q     (slot_q[i])
        );
    end

    // Registered read data and error pulse
    clkrst_read_path #(
        .DW (DATA_W_P),
        .NS (NS)
    ) u_rdp (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .hit   (hit),
        .sel   (sel),
        .slots (slot_q),
        .rdata (bus_rdata),
        .err   (bus_err)
    );

    // R8
    short_access_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_size != 2'd2) |=> bus_err);

    // R9
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !$past(bus_rd || bus_wr)) |-> 1'b0);

endmodule

// File: tb/clkrst_cfg_regs_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a register model kept in the bench.
module clkrst_cfg_regs_tb;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NS = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd2;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          bus_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [DW-1:0] model [NS];

    always #4 clk = ~clk;   // 125 MHz

    clkrst_cfg_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    function automatic int off_of(input int i);
        int t [NS] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h1C, 'h24, 'h28, 'h2C};
        return t[i];
    endfunction

    function automatic logic [DW-1:0] por_of(input int i);
        if (i == 0) return 32'hC000_0000;
        if (i == 1 || i == 2 || i == 4) return 32'h8201_87C1;
        if (i == 6) return 32'h0000_0001;
        return 32'h0;
    endfunction

    function automatic logic [DW-1:0] ones_of(input int i);
        if (i == 0) return 32'h8000_0000;
        if (i == 1 || i == 2 || i == 4) return 32'h8200_0000;
        return 32'h0;
    endfunction

    // Returns slot index of an address or -1
    function automatic int slot_at(input logic [AW-1:0] a);
        for (int i = 0; i < NS; i++) if (int'(a) == off_of(i)) return i;
        return -1;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One bus cycle; result sampled at the following negedge
    task automatic bus_cycle(input logic [AW-1:0] a, input logic [1:0] sz,
                             input logic wr, input logic [DW-1:0] d, input logic rd);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wr = wr; bus_wdata = d; bus_rd = rd;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic do_write(input string tag, input logic [AW-1:0] a, input logic [1:0] sz,
                            input logic [DW-1:0] d);
        int s;
        bit legal;
        s = slot_at(a);
        legal = (s >= 0) && (sz == 2'd2);
        bus_cycle(a, sz, 1'b1, d, 1'b0);
        if (legal) model[s] = d | ones_of(s);
        check({tag, " err"}, {31'b0, bus_err}, {31'b0, !legal});
    endtask

    task automatic do_read(input string tag, input logic [AW-1:0] a, input logic [1:0] sz);
        int s;
        bit legal;
        s = slot_at(a);
        legal = (s >= 0) && (sz == 2'd2);
        bus_cycle(a, sz, 1'b0, '0, 1'b1);
        check({tag, " data"}, bus_rdata, legal ? model[s] : 32'h0);
        check({tag, " err"}, {31'b0, bus_err}, {31'b0, !legal});
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NS; i++) do_read(tag, AW'(off_of(i)), 2'd2);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        void'($urandom(32'h0C1A_5EED));
        for (int i = 0; i < NS; i++) model[i] = por_of(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset err", {31'b0, bus_err}, 32'h0);
        check("R5 reset rdata", bus_rdata, 32'h0);

        // R1 power-on values
        read_all("R1 por");

        // R2 oscillator: ready forced, enable writable
        do_write("R2 osc wr", 6'h00, 2'd2, 32'h0000_0000);
        do_read("R2 osc rd", 6'h00, 2'd2);
        check("R2 osc value", bus_rdata, 32'h8000_0000);

        // R3 PLL first words
        do_write("R3 cpll wr", 6'h04, 2'd2, 32'h0000_1234);
        do_read("R3 cpll rd", 6'h04, 2'd2);
        check("R3 cpll value", bus_rdata, 32'h8200_1234);
        do_write("R3 mpll wr", 6'h08, 2'd2, 32'h7DFF_FFFF);
        do_read("R3 mpll rd", 6'h08, 2'd2);
        do_write("R3 npll wr", 6'h10, 2'd2, 32'h0);
        do_read("R3 npll rd", 6'h10, 2'd2);

        // R4 plain slots
        do_write("R4 mpllb", 6'h0C, 2'd2, 32'hFFFF_FFFF);
        do_write("R4 npllb", 6'h1C, 2'd2, 32'hA5A5_5A5A);
        do_write("R4 src", 6'h24, 2'd2, 32'h0);
        do_write("R4 devrst", 6'h28, 2'd2, 32'h1357_9BDF);
        do_write("R4 mux", 6'h2C, 2'd2, 32'hDEAD_BEEF);
        read_all("R4 readback");

        // R5 hold without read
        held = bus_rdata;
        @(negedge clk);
        check("R5 hold", bus_rdata, held);
        do_write("R5 write no rd", 6'h28, 2'd2, 32'h0F0F_0F0F);
        check("R5 hold after write", bus_rdata, held);

        // R6/R10 refused reads: gap, misaligned, out of window
        do_read("R6 gap 0x14", 6'h14, 2'd2);
        do_read("R10 gap 0x20", 6'h20, 2'd2);
        do_read("R10 misaligned 0x05", 6'h05, 2'd2);
        do_read("R10 above 0x30", 6'h30, 2'd2);
        do_read("R10 above 0x3C", 6'h3C, 2'd2);

        // R9 err is a single pulse
        @(negedge clk);
        check("R9 err falls", {31'b0, bus_err}, 32'h0);

        // R8 short sizes refused at a mapped offset
        do_read("R8 byte rd", 6'h28, 2'd0);
        do_read("R8 half rd", 6'h28, 2'd1);
        do_read("R8 rsvd rd", 6'h28, 2'd3);
        do_write("R8 byte wr", 6'h28, 2'd0, 32'hFFFF_FFFF);
        do_write("R8 rsvd wr", 6'h00, 2'd3, 32'h0);

        // R7 refused writes change nothing
        do_write("R7 gap wr", 6'h18, 2'd2, 32'hFFFF_FFFF);
        do_write("R7 misaligned wr", 6'h26, 2'd2, 32'hFFFF_FFFF);
        do_write("R7 above wr", 6'h34, 2'd2, 32'hFFFF_FFFF);
        read_all("R7 unchanged");

        // Random traffic against the model
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            logic [1:0]    sz;
            int            pick;
            pick = int'($urandom_range(0, 9));
            if (pick < 7) a = AW'(off_of(int'($urandom_range(0, NS - 1))));
            else          a = AW'($urandom);
            sz = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'd2;
            if ($urandom_range(0, 1) == 0) do_write("R4 rand wr", a, sz, $urandom);
            else                           do_read("R5 rand rd", a, sz);
        end
        read_all("R3 final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule